// File: doc/BRIEF.md
# Prefetch Burst Serializer

This block turns one prefetched column word (eight bits per data pin by default) into a double-data-rate serial stream for that pin. The word is split into an even half and an odd half. Bit i of the word is the bit at column offset i, so the even half holds word bits 0, 2, 4, 6 and the odd half holds bits 1, 3, 5, 7. Each half has its own one-hot ring pointer. On every internal clock cycle of a burst, each pointer picks one bit, so one even and one odd bit move together into a two-slot staging register. A reorder step puts the bit that is earlier in burst order into the first slot. A final select driven by the clock level sends the first slot to the pin while the clock is high and the second slot while it is low. One internal cycle therefore carries two pin bits, and four cycles drain a word.

The input side is valid/ready. A word and its starting column offset are taken on a rising edge where `in_valid` and `in_ready` are both high. The sender must hold the word and the offset stable while `in_ready` is low. The output side has no back-pressure, because a pin cannot stall. `ser_valid` marks the cycles that carry burst data. `in_ready` rises again on the cycle of the last pair transfer, so a waiting word follows with no gap in the stream.

Top module: `pbs_serializer`

## Requirements
- R1: A synchronous active-high `rst` clears both pointers and the staging slots and stops any burst in progress. After the reset edge, `ser_valid` is 0, `in_ready` is 1 and `ser_data` is 0.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 whenever no burst is in progress.
- R3: During a burst, each pointer is one-hot. Each pointer advances by one position per cycle and wraps from the top position back to position 0. Four pair transfers drain one word.
- R4: For an even start offset s (`in_col` bit 0 = 0), both pointers start at position s/2 and the even bit of each pair is emitted first. The pin order is s, s+1, …, wrapping modulo 8.
- R5: For an odd start offset s, the odd pointer starts at position (s-1)/2 and the even pointer starts one position further on, modulo 4. The odd bit of each pair is emitted first. For example, start 1 gives 1,2,…,7,0 and start 7 gives 7,0,1,…,6.
- R6: After a word is accepted, `in_ready` is 0 for the first three transfer cycles and 1 on the fourth. A word presented then is accepted on the same edge as the last transfer, and `ser_valid` stays 1 across the boundary between the two bursts.
- R7: The first pair of a burst reaches the pin in the cycle after the edge following acceptance. The first bit is driven while `clk` is high and the second while `clk` is low. An isolated burst keeps `ser_valid` high for exactly four cycles.
- R8: `ser_data` is 0 whenever `ser_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; one pair per cycle, and its level picks the output bit |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Prefetch word and offset are presented |
| in_ready | output | 1 | Block can take a word on this edge |
| in_word | input | PF_BITS | Prefetched burst bits, bit i = column offset i |
| in_col | input | log2(PF_BITS) | Starting column offset of the burst |
| ser_data | output | 1 | Double-data-rate serial output |
| ser_valid | output | 1 | Current cycle carries burst data |

## Verification
Every start offset from 0 to 7 is driven with two asymmetric words. A design with a wrong even-pointer offset, a reversed reorder, or no wrap of the even pointer at start 7 produces a rotated or pair-swapped bit order. Two words are sent back to back at the last-transfer edge. A ready signal that rises one cycle late would leave a low gap in `ser_valid`, and a load that takes priority over the transfer would drop the final pair. The ready window, the one-cycle output latency and the idle-low data are sampled on both clock phases. A reset in mid-burst must stop the stream at once and leave the next burst clean.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  // which half of a pointer-selected pair leaves the pin first
  typedef enum logic {
    ORDER_EVEN_FIRST = 1'b0,
    ORDER_ODD_FIRST  = 1'b1
  } pair_order_e;
endpackage

// File: rtl/pbs_ptr_ring.sv
module pbs_ptr_ring #(
  parameter int SLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [$clog2(SLOTS)-1:0] start_idx,
  input  logic                     step,
  output logic [SLOTS-1:0]         ptr
);
  localparam logic [SLOTS-1:0] ONE = {{(SLOTS-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= ONE << start_idx;
    else if (step) ptr <= {ptr[SLOTS-2:0], ptr[SLOTS-1]};
  end
endmodule

// File: rtl/pbs_pair_stage.sv
module pbs_pair_stage
  import pbs_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer,
  input  pair_order_e      order,
  input  logic [SLOTS-1:0] half_e,
  input  logic [SLOTS-1:0] half_o,
  input  logic [SLOTS-1:0] ptr_e,
  input  logic [SLOTS-1:0] ptr_o,
  output logic             slot_first,
  output logic             slot_second,
  output logic             slot_valid
);
  logic bit_e, bit_o;

  assign bit_e = |(half_e & ptr_e);
  assign bit_o = |(half_o & ptr_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_first  <= 1'b0;
      slot_second <= 1'b0;
      slot_valid  <= 1'b0;
    end else begin
      slot_valid <= xfer;
      if (xfer) begin
        if (order == ORDER_ODD_FIRST) begin
          slot_first  <= bit_o;
          slot_second <= bit_e;
        end else begin
          slot_first  <= bit_e;
          slot_second <= bit_o;
        end
      end
    end
  end
endmodule

// File: rtl/pbs_ddr_sel.sv
module pbs_ddr_sel (
  input  logic phase,
  input  logic first,
  input  logic second,
  input  logic valid,
  output logic pin
);
  assign pin = valid & (phase ? first : second);
endmodule

// File: rtl/pbs_serializer.sv
module pbs_serializer
  import pbs_pkg::*;
#(
  parameter int PF_BITS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [PF_BITS-1:0]         in_word,
  input  logic [$clog2(PF_BITS)-1:0] in_col,
  output logic                       ser_data,
  output logic                       ser_valid
);
  localparam int HALF  = PF_BITS / 2;
  localparam int PTR_W = $clog2(HALF);
  localparam int OFS_W = $clog2(PF_BITS);

  logic [PF_BITS-1:0] word_q;
  logic [HALF-1:0]    half_e, half_o, ptr_e, ptr_o;
  logic [PTR_W-1:0]   cnt_q, idx_o, idx_e;
  logic               busy_q, load, last;
  pair_order_e        order_q;
  logic               slot_first, slot_second, slot_valid;

  for (genvar g = 0; g < HALF; g++) begin : g_split
    assign half_e[g] = word_q[2*g];
    assign half_o[g] = word_q[2*g+1];
  end

  assign last     = (cnt_q == PTR_W'(HALF - 1));
  assign in_ready = !busy_q || last;
  assign load     = in_valid && in_ready;
  assign idx_o    = in_col[OFS_W-1:1];
  assign idx_e    = idx_o + PTR_W'(in_col[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      word_q  <= '0;
      order_q <= ORDER_EVEN_FIRST;
    end else if (load) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      word_q  <= in_word;
      order_q <= in_col[0] ? ORDER_ODD_FIRST : ORDER_EVEN_FIRST;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  pbs_ptr_ring #(.SLOTS(HALF)) u_ring_e (
    .clk(clk), .rst(rst), .load(load), .start_idx(idx_e), .step(busy_q), .ptr(ptr_e)
  );

  pbs_ptr_ring #(.SLOTS(HALF)) u_ring_o (
    .clk(clk), .rst(rst), .load(load), .start_idx(idx_o), .step(busy_q), .ptr(ptr_o)
  );

  pbs_pair_stage #(.SLOTS(HALF)) u_stage (
    .clk(clk), .rst(rst), .xfer(busy_q), .order(order_q),
    .half_e(half_e), .half_o(half_o), .ptr_e(ptr_e), .ptr_o(ptr_o),
    .slot_first(slot_first), .slot_second(slot_second), .slot_valid(slot_valid)
  );

  pbs_ddr_sel u_sel (
    .phase(clk), .first(slot_first), .second(slot_second), .valid(slot_valid), .pin(ser_data)
  );

  assign ser_valid = slot_valid;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int HALF = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            col_odd,
  input logic            busy,
  input logic [HALF-1:0] ptr_e,
  input logic [HALF-1:0] ptr_o,
  input logic            ser_valid
);
  assert_ptr_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(ptr_e) == 1 && $countones(ptr_o) == 1));

  assert_ptr_idle_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ptr_e) && $onehot0(ptr_o));

  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !(in_valid && in_ready)) |=>
      ptr_e == {$past(ptr_e[HALF-2:0]), $past(ptr_e[HALF-1])});

  assert_even_start_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !col_odd) |=> ptr_e == ptr_o);

  assert_odd_start_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && col_odd) |=> ptr_e == {ptr_o[HALF-2:0], ptr_o[HALF-1]});

  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 ser_valid);
endmodule

bind pbs_serializer pbs_checker #(.HALF(HALF)) u_pbs_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .col_odd(in_col[0]), .busy(busy_q), .ptr_e(ptr_e), .ptr_o(ptr_o),
  .ser_valid(ser_valid)
);

// File: tb/test_pbs_serializer.sv
`timescale 1ns/1ps
module test_pbs_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_word = '0;
  logic [2:0] in_col = '0;
  logic       ser_data, ser_valid;

  int   errors = 0, checks = 0, ncap = 0;
  logic cap [0:31];
  bit   done = 0;

  always #2.5 clk = ~clk;

  pbs_serializer #(.PF_BITS(8)) i_pbs_serializer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_col(in_col), .ser_data(ser_data), .ser_valid(ser_valid)
  );

  // capture every valid pin bit: high phase then low phase
  always @(posedge clk) begin
    #1;
    if (ser_valid && ncap < 32) begin cap[ncap] = ser_data; ncap++; end
  end
  always @(negedge clk) begin
    #1;
    if (ser_valid && ncap < 32) begin cap[ncap] = ser_data; ncap++; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_order(input logic [7:0] w, input int s);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = w[(s + k) % 8];
    return r;
  endfunction

  function automatic logic [7:0] got_order(input int base);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = cap[base + k];
    return r;
  endfunction

  task automatic send_one(input logic [7:0] w, input logic [2:0] c);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_word = w; in_col = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check(ser_valid == 1'b0, "R1 valid after reset", ser_valid, 0);
    check(in_ready == 1'b1, "R1/R2 ready after reset", in_ready, 1);
    check(ser_data == 1'b0, "R1/R8 data low phase after reset", ser_data, 0);
    @(posedge clk); #1;
    check(ser_data == 1'b0, "R8 data high phase idle", ser_data, 0);
  endtask

  task automatic run_single(input logic [7:0] w, input int s, input string req);
    ncap = 0;
    send_one(w, 3'(s));
    repeat (6) @(posedge clk);
    check(ncap == 8, {req, " bit count"}, ncap, 8);
    check(got_order(0) == exp_order(w, s), {req, " order"}, got_order(0), exp_order(w, s));
  endtask

  task automatic t_all_starts;
    for (int s = 0; s < 8; s++) begin
      run_single(8'hB4, s, (s % 2 == 0) ? "R4 even start" : "R5 odd start");
      run_single(8'h6D, s, (s % 2 == 0) ? "R4 even start" : "R5 odd start");
    end
  endtask

  task automatic t_window;
    ncap = 0;
    @(negedge clk);
    in_valid = 1'b1; in_word = 8'hC3; in_col = 3'd5;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0; #1;
    check(in_ready == 1'b0, "R6 ready low cycle1", in_ready, 0);
    check(ser_valid == 1'b0, "R7 no output before first transfer", ser_valid, 0);
    @(negedge clk); #1;
    check(in_ready == 1'b0, "R6 ready low cycle2", in_ready, 0);
    check(ser_valid == 1'b1, "R7 first pair one cycle after accept", ser_valid, 1);
    @(negedge clk); #1;
    check(in_ready == 1'b0, "R6 ready low cycle3", in_ready, 0);
    @(negedge clk); #1;
    check(in_ready == 1'b1, "R6 ready on last transfer", in_ready, 1);
    @(negedge clk); #1;
    check(ser_valid == 1'b1, "R7 fourth valid cycle", ser_valid, 1);
    @(negedge clk); #1;
    check(ser_valid == 1'b0, "R7 valid ends after four cycles", ser_valid, 0);
    check(ser_data == 1'b0, "R8 data low after burst", ser_data, 0);
    check(ncap == 8, "R7 isolated burst bit count", ncap, 8);
    check(got_order(0) == exp_order(8'hC3, 5), "R5 start 5 order", got_order(0), exp_order(8'hC3, 5));
  endtask

  task automatic t_back_to_back;
    int drops = 0;
    ncap = 0;
    @(negedge clk);
    fork
      begin
        in_valid = 1'b1; in_word = 8'h5A; in_col = 3'd3;
        @(posedge clk);
        @(negedge clk);
        in_word = 8'h27; in_col = 3'd6;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        @(posedge clk);
        repeat (8) begin
          @(posedge clk); #1;
          if (!ser_valid) drops++;
        end
      end
    join
    repeat (4) @(posedge clk);
    check(drops == 0, "R6 valid continuous across bursts", drops, 0);
    check(ncap == 16, "R6 back-to-back bit count", ncap, 16);
    check(got_order(0) == exp_order(8'h5A, 3), "R6 first word order", got_order(0), exp_order(8'h5A, 3));
    check(got_order(8) == exp_order(8'h27, 6), "R6 second word order", got_order(8), exp_order(8'h27, 6));
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    in_valid = 1'b1; in_word = 8'hFF; in_col = 3'd2;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check(ser_valid == 1'b0, "R1 mid-burst reset stops output", ser_valid, 0);
    check(in_ready == 1'b1, "R1 ready after mid-burst reset", in_ready, 1);
    @(posedge clk); #1;
    check(ser_valid == 1'b0, "R1 no leftover pairs", ser_valid, 0);
    run_single(8'h96, 7, "R1 clean burst after reset");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_all_starts();
    t_window();
    t_back_to_back();
    t_reset_mid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule